// File: doc/BRIEF.md
# Programmable Counter Timebase Unit

This block is a 16-bit free-running up-counter that software reaches as two byte-wide registers on a small register bus. Each cycle the counter advances by one, or holds, depending on a count enable. A three-bit select field picks the source of that enable from six choices: the system clock divided by twelve, the system clock divided by four, every system clock, a one-cycle overflow pulse from a neighbouring timer, falling edges on an external count pin, or an external oscillator divided by eight. The two external pins are asynchronous and pass through two-flop synchronizers before any edge is detected. Each detected event yields a single-cycle enable.

A 16-bit value cannot be read in one byte access while it keeps moving. To keep such reads coherent, a read of the low byte copies the high byte into a snapshot register, and a read of the high byte returns that snapshot. Software reads the low byte first and the high byte second. When the counter rolls over from all ones to zero, a sticky overflow flag is set. That flag requests an interrupt when the enable bit allows it. An idle input can stop counting, but only when the idle-hold bit is set.

The unit carries no data stream. The bus is a plain strobe interface with no back-pressure: a write takes effect at the clock edge where it is presented, and read data follows the address within the same cycle.

Top module: `pct_timebase`

## Requirements
- R1: After reset the counter, the snapshot, the mode register and the overflow flag are all zero, and irq_out is low.
- R2: A write to address 0 loads the counter's low byte and a write to address 1 loads its high byte. In the cycle of such a write the counter does not increment and the overflow flag cannot be set.
- R3: A read of address 0 returns the live low byte and copies the live high byte into the snapshot. A read of address 1 returns the snapshot, not the live high byte.
- R4: Reads never change the counter value or its rate of counting.
- R5: With select code 100 (mode register bits 3:1) the counter advances on every clock.
- R6: With select code 000 the counter advances once every 12 clocks. With code 001 it advances once every 4 clocks. The prescalers run freely.
- R7: With select code 010 the counter advances once for each clock in which t_ovf_in is high.
- R8: With select code 011 the counter advances once per high-to-low transition of ext_cnt_in, after a two-flop synchronizer. Each level must last at least two clocks, so the edge rate stays at or below a quarter of the clock rate.
- R9: With select code 101 the counter advances once per eight rising edges of ext_osc_in, after a two-flop synchronizer. ext_osc_in must run no faster than the clock.
- R10: Select codes 110 and 111 produce no count enable, so the counter holds.
- R11: An increment from 0xFFFF to 0x0000 sets the overflow flag, read at bit 0 of address 3. The flag stays set until a write of 0 to that bit clears it. Writing 1 has no effect. A wrap in the same cycle as a clear leaves the flag set.
- R12: irq_out is high exactly when the overflow flag is 1 and the interrupt enable (mode bit 0) is 1.
- R13: When idle-hold (mode bit 7) is 1 and idle_in is high, counting stops. When idle-hold is 0, idle_in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 mode, 3 status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; only used for the snapshot capture |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| t_ovf_in | input | 1 | Synchronous overflow pulse from another timer |
| ext_cnt_in | input | 1 | Asynchronous external count input |
| ext_osc_in | input | 1 | Asynchronous external oscillator |
| idle_in | input | 1 | Idle indication |
| irq_out | output | 1 | Overflow interrupt request |

## Verification
The assertions check the per-cycle rules on every clock: counter steps are at most one, a byte write loads exactly the written value, reserved select codes and the idle-hold freeze keep the count still, the flag is sticky, the interrupt gating holds, and the falling-edge mode never produces two enables in a row. The scenarios are needed for what spans many cycles or depends on ordering. These include the exact divide ratios of the prescalers over whole windows and the count of events from the timer pulse, the count pin and the oscillator. They also cover the snapshot returning a stale high byte after a later write, the exact wrap value with the flag set, and the rule that reads leave the total count unchanged.

// File: rtl/pct_pkg.sv
package pct_pkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] SEL_DIV12   = 3'b000;
  localparam logic [2:0] SEL_DIV4    = 3'b001;
  localparam logic [2:0] SEL_TMR_OVF = 3'b010;
  localparam logic [2:0] SEL_EXT_FALL = 3'b011;
  localparam logic [2:0] SEL_SYSCLK  = 3'b100;
  localparam logic [2:0] SEL_OSC_DIV = 3'b101;

  localparam logic [1:0] ADDR_LO     = 2'd0;
  localparam logic [1:0] ADDR_HI     = 2'd1;
  localparam logic [1:0] ADDR_MODE   = 2'd2;
  localparam logic [1:0] ADDR_STATUS = 2'd3;

  typedef struct packed {
    logic       idle_hold;
    logic [2:0] sel;
    logic       irq_en;
  } mode_t;
endpackage

// File: rtl/pct_sync.sv
module pct_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pct_prescaler.sv
module pct_prescaler #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/pct_tick_gen.sv
module pct_tick_gen
  import pct_pkg::*;
#(
  parameter int SLOW_DIV  = 12,
  parameter int FAST_DIV  = 4,
  parameter int OSC_DIV   = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       t_ovf,
  input  logic       ext_cnt,
  input  logic       ext_osc,
  output logic       tick
);
  localparam int OW = $clog2(OSC_DIV);
  localparam logic [OW-1:0] OSC_LAST = OW'(OSC_DIV - 1);

  logic tick_slow, tick_fast;
  logic ext_s, ext_prev, ext_fall;
  logic osc_s, osc_prev, osc_rise, osc_tick;
  logic [OW-1:0] osc_cnt;

  pct_prescaler #(.DIV(SLOW_DIV)) u_pre_slow (.clk(clk), .rst_n(rst_n), .tick(tick_slow));
  pct_prescaler #(.DIV(FAST_DIV)) u_pre_fast (.clk(clk), .rst_n(rst_n), .tick(tick_fast));

  pct_sync #(.STAGES(SYNC_STG)) u_sync_ext (.clk(clk), .rst_n(rst_n), .d(ext_cnt), .q(ext_s));
  pct_sync #(.STAGES(SYNC_STG)) u_sync_osc (.clk(clk), .rst_n(rst_n), .d(ext_osc), .q(osc_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      osc_prev <= 1'b0;
      osc_cnt  <= '0;
    end else begin
      ext_prev <= ext_s;
      osc_prev <= osc_s;
      if (osc_rise) osc_cnt <= (osc_cnt == OSC_LAST) ? '0 : osc_cnt + 1'b1;
    end
  end

  assign ext_fall = ext_prev & ~ext_s;
  assign osc_rise = osc_s & ~osc_prev;
  assign osc_tick = osc_rise & (osc_cnt == OSC_LAST);

  always_comb begin
    unique case (sel)
      SEL_DIV12:    tick = tick_slow;
      SEL_DIV4:     tick = tick_fast;
      SEL_TMR_OVF:  tick = t_ovf;
      SEL_EXT_FALL: tick = ext_fall;
      SEL_SYSCLK:   tick = 1'b1;
      SEL_OSC_DIV:  tick = osc_tick;
      default:      tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/pct_counter.sv
module pct_counter
  import pct_pkg::*;
#(
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [BW-1:0] wdata,
  input  logic          snap_cap,
  output logic [2*BW-1:0] cnt,
  output logic [BW-1:0] snap,
  output logic          wrap
);
  localparam int CW = 2 * BW;

  logic step;

  assign step = inc & ~wr_lo & ~wr_hi;
  assign wrap = step & (&cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cnt[BW-1:0]  <= wdata;
      if (wr_hi) cnt[CW-1:BW] <= wdata;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        snap <= '0;
    else if (snap_cap) snap <= cnt[CW-1:BW];
  end
endmodule

// File: rtl/pct_timebase.sv
module pct_timebase
  import pct_pkg::*;
#(
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4,
  parameter int OSC_DIV  = 8,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       t_ovf_in,
  input  logic       ext_cnt_in,
  input  logic       ext_osc_in,
  input  logic       idle_in,
  output logic       irq_out
);
  mode_t mode;
  logic  flag;
  logic  tick, inc, wrap;
  logic  wr_lo, wr_hi, wr_mode, wr_stat;
  logic [15:0] cnt;
  logic [7:0]  snap;

  assign wr_lo   = bus_wr && bus_addr == ADDR_LO;
  assign wr_hi   = bus_wr && bus_addr == ADDR_HI;
  assign wr_mode = bus_wr && bus_addr == ADDR_MODE;
  assign wr_stat = bus_wr && bus_addr == ADDR_STATUS;

  pct_tick_gen #(
    .SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV), .OSC_DIV(OSC_DIV), .SYNC_STG(SYNC_STG)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(mode.sel), .t_ovf(t_ovf_in),
    .ext_cnt(ext_cnt_in), .ext_osc(ext_osc_in), .tick(tick)
  );

  assign inc = tick & ~(mode.idle_hold & idle_in);

  pct_counter #(.BW(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .wdata(bus_wdata), .snap_cap(bus_rd && bus_addr == ADDR_LO),
    .cnt(cnt), .snap(snap), .wrap(wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_mode) mode <= '{idle_hold: bus_wdata[7], sel: bus_wdata[3:1], irq_en: bus_wdata[0]};
      if (wrap)                         flag <= 1'b1;
      else if (wr_stat && !bus_wdata[0]) flag <= 1'b0;
    end
  end

  assign irq_out = flag & mode.irq_en;

  always_comb begin
    unique case (bus_addr)
      ADDR_LO:   bus_rdata = cnt[7:0];
      ADDR_HI:   bus_rdata = snap;
      ADDR_MODE: bus_rdata = {mode.idle_hold, 3'b000, mode.sel, mode.irq_en};
      default:   bus_rdata = {7'b0, flag};
    endcase
  end
endmodule

// File: rtl/pct_timebase_chk.sv
module pct_timebase_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  bus_addr,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic [2:0]  sel,
  input logic        idle_hold,
  input logic        irq_en,
  input logic        idle_in,
  input logic        inc,
  input logic        flag,
  input logic        irq_out,
  input logic [15:0] cnt
);
  // R2
  lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 2'd0 |=> cnt[7:0] == $past(bus_wdata));

  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> (cnt == $past(cnt)) || (cnt == 16'($past(cnt) + 16'd1)));

  // R10
  reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'b110 || sel == 3'b111) && !bus_wr |=> $stable(cnt));

  // R13
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_hold && idle_in && !bus_wr |=> $stable(cnt));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(bus_wr && bus_addr == 2'd3 && !bus_wdata[0]) |=> flag);

  // R12
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq_out);

  // R12
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag && irq_en |-> irq_out);

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel == 3'b011 && inc |=> !inc || sel != 3'b011);
endmodule

bind pct_timebase pct_timebase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .sel(mode.sel), .idle_hold(mode.idle_hold),
  .irq_en(mode.irq_en), .idle_in(idle_in), .inc(inc), .flag(flag),
  .irq_out(irq_out), .cnt(cnt)
);

// File: tb/pct_timebase_tb.sv
`timescale 1ns/1ps
module pct_timebase_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       t_ovf_in = 1'b0, ext_cnt_in = 1'b0, ext_osc_in = 1'b0;
  logic       idle_in = 1'b1;
  logic       irq_out;
  logic       mon_en = 1'b0;
  logic       done = 1'b0;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;
  always #5 ext_osc_in = ~ext_osc_in;

  pct_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .t_ovf_in(t_ovf_in),
    .ext_cnt_in(ext_cnt_in), .ext_osc_in(ext_osc_in), .idle_in(idle_in), .irq_out(irq_out)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: read 0x%02h expected 0x%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1 bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string t);
    @(posedge clk); #1 bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t); mon_en = 1'b1;
    @(posedge clk); #1 bus_rd = 1'b0; mon_en = 1'b0;
  endtask

  task automatic rd_val(input logic [1:0] a, output logic [7:0] v);
    @(posedge clk); #1 bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); v = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic set_idle(input logic v);
    @(posedge clk); #1 idle_in = v;
  endtask

  task automatic chk_bit(input logic act, input logic e, input string t);
    n_chk++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", t, act, e);
    end
  endtask

  task automatic chk_range(input logic [7:0] v, input int lo, input int hi, input string t);
    n_chk++;
    if (v < lo || v > hi) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d..%0d", t, v, lo, hi);
    end
  endtask

  task automatic zero_cnt;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
  endtask

  task automatic finish_up;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk_bit(irq_out, 1'b0, "R1 irq after reset");
    rd_exp(2'd2, 8'h00, "R1 mode reset");
    rd_exp(2'd3, 8'h00, "R1 flag reset");
    rd_exp(2'd1, 8'h00, "R1 snapshot reset");

    // freeze with reserved code, load both bytes
    wr(2'd2, 8'h0E);
    wr(2'd1, 8'h12); wr(2'd0, 8'h34);
    repeat (20) @(posedge clk);
    rd_exp(2'd0, 8'h34, "R2 R10 low load held");
    rd_exp(2'd1, 8'h12, "R2 high load");

    // snapshot coherence
    wr(2'd1, 8'hAB); wr(2'd0, 8'hFE);
    rd_exp(2'd0, 8'hFE, "R3 low read");
    wr(2'd1, 8'h55);
    rd_exp(2'd1, 8'hAB, "R3 stale snapshot");
    rd_exp(2'd0, 8'hFE, "R3 low reread");
    rd_exp(2'd1, 8'h55, "R3 fresh snapshot");

    // write priority over increment while running every clock
    zero_cnt();
    wr(2'd2, 8'h08);
    wr(2'd0, 8'h40);
    wr(2'd2, 8'h0E);
    rd_exp(2'd0, 8'h42, "R2 write wins over increment");

    // wrap under idle-hold gating
    wr(2'd2, 8'h88);
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFD);
    set_idle(1'b0);
    repeat (4) @(posedge clk);
    set_idle(1'b1);
    rd_exp(2'd0, 8'h02, "R11 R13 wrap value low");
    rd_exp(2'd1, 8'h00, "R11 wrap value high");
    rd_exp(2'd3, 8'h01, "R11 flag set");
    @(negedge clk); chk_bit(irq_out, 1'b0, "R12 masked irq");
    wr(2'd2, 8'h89);
    @(negedge clk); chk_bit(irq_out, 1'b1, "R12 irq raised");
    wr(2'd3, 8'h01);
    rd_exp(2'd3, 8'h01, "R11 write one keeps flag");
    wr(2'd3, 8'h00);
    rd_exp(2'd3, 8'h00, "R11 write zero clears");
    @(negedge clk); chk_bit(irq_out, 1'b0, "R12 irq drops");

    // idle has no effect when hold is 0
    wr(2'd2, 8'h0E); zero_cnt();
    wr(2'd2, 8'h08);
    repeat (8) @(posedge clk);
    wr(2'd2, 8'h0E);
    rd_exp(2'd0, 8'h0A, "R5 R13 count through idle");

    // hold set: frozen
    wr(2'd2, 8'h88);
    repeat (8) @(posedge clk);
    wr(2'd2, 8'h8E);
    rd_exp(2'd0, 8'h0A, "R13 frozen in idle");

    // reads do not disturb counting
    wr(2'd2, 8'h08);
    rd_val(2'd0, v); rd_val(2'd0, v); rd_val(2'd0, v);
    wr(2'd2, 8'h0E);
    rd_exp(2'd0, 8'h12, "R4 reads keep count");

    // divide by 4
    zero_cnt();
    wr(2'd2, 8'h02);
    repeat (38) @(posedge clk);
    wr(2'd2, 8'h0E);
    rd_exp(2'd0, 8'd10, "R6 divide by 4");

    // divide by 12
    zero_cnt();
    wr(2'd2, 8'h00);
    repeat (130) @(posedge clk);
    wr(2'd2, 8'h0E);
    rd_exp(2'd0, 8'd11, "R6 divide by 12");

    // timer overflow pulses
    zero_cnt();
    wr(2'd2, 8'h04);
    for (int i = 0; i < 7; i++) begin
      @(posedge clk); #1 t_ovf_in = 1'b1;
      @(posedge clk); #1 t_ovf_in = 1'b0;
      repeat (2) @(posedge clk);
    end
    wr(2'd2, 8'h0E);
    rd_exp(2'd0, 8'd7, "R7 timer pulses");

    // falling edges on the count input
    zero_cnt();
    ext_cnt_in = 1'b1;
    repeat (6) @(posedge clk);
    wr(2'd2, 8'h06);
    for (int i = 0; i < 6; i++) begin
      repeat (4) @(posedge clk); #1 ext_cnt_in = 1'b0;
      repeat (4) @(posedge clk); #1 ext_cnt_in = 1'b1;
    end
    repeat (6) @(posedge clk);
    wr(2'd2, 8'h0E);
    rd_exp(2'd0, 8'd6, "R8 falling edges");

    // external oscillator divided by 8
    zero_cnt();
    wr(2'd2, 8'h0A);
    repeat (198) @(posedge clk);
    wr(2'd2, 8'h0E);
    rd_val(2'd0, v);
    chk_range(v, 9, 11, "R9 oscillator divide");

    repeat (4) @(posedge clk);
    finish_up();
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      finish_up();
    end
  end
endmodule